// File: doc/BRIEF.md
# Hamming Code Generator for Flash Page Chunks

This block takes a flash page as a stream of bytes and produces a 24-bit single-error-correcting Hamming code for every 256-byte chunk of that page. One byte is accepted per cycle on a valid/ready interface. A start-of-page flag on the first byte restarts the in-chunk byte position and the chunk counter. The block keeps a running set of column parities, which depend on which bits of each byte are set. It also keeps a set of row parities, which depend on where in the chunk each odd-parity byte sits.

When the 256th byte of a chunk is accepted, the code for that chunk is inverted and its two spare low bits are set. The next cycle it appears on the output with a one-cycle valid pulse and the number of the chunk within the page. Chunks of one page follow each other with no idle cycle. The accumulators restart on the first byte of every chunk. A page of N×256 bytes therefore gives N codes in chunk order. Placing the codes in the spare area and correcting errors are left to other logic.

Top module: `hamming_ecc_gen`

## Requirements
- R1: While reset is high, `out_valid` is 0. From the first cycle after reset is released, `in_ready` is 1 and stays 1, so a byte is accepted in every cycle that `in_valid` is 1.
- R2: Code byte 0 is `out_code[7:0]`. Its bits 7..2 hold the inverted XOR, over all 256 bytes of the chunk, of these data bit groups: bit 2 of {0,2,4,6}, bit 3 of {1,3,5,7}, bit 4 of {0,1,4,5}, bit 5 of {2,3,6,7}, bit 6 of {0,1,2,3}, and bit 7 of {4,5,6,7}.
- R3: Code byte 2 is `out_code[23:16]`. For every data byte with odd parity at in-chunk position p (0..255), and for each k in 0..3, bit 2k+p[k] is toggled. The accumulated value is inverted at the end.
- R4: Code byte 1 is `out_code[15:8]`. For every data byte with odd parity at in-chunk position p, and for each k in 0..3, bit 2k+p[k+4] is toggled. The accumulated value is inverted at the end.
- R5: Whenever `out_valid` is 1, `out_code[1:0]` is 2'b11.
- R6: `out_valid` is 1 for exactly one cycle: the cycle right after the 256th byte of a chunk is accepted. It is 0 in every other cycle.
- R7: `out_chunk` is 0 for the first chunk after a start-of-page byte and rises by one for each later chunk of the page. It wraps modulo 2^CHUNK_CNT_W.
- R8: The code of each chunk depends only on that chunk's bytes. A chunk that follows another one back to back with no idle cycle starts from a cleared accumulator.
- R9: A byte accepted with `in_sop`=1 is position 0 of chunk 0. Any partly received chunk is dropped and produces no code.
- R10: Cycles with `in_valid`=0 change neither the byte position nor the accumulators, whatever `in_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Block accepts a byte |
| in_sop | input | 1 | Byte is the first of a page |
| in_data | input | 8 | Data byte |
| out_valid | output | 1 | One-cycle pulse, code valid |
| out_code | output | 24 | {byte 2, byte 1, byte 0} of the chunk code |
| out_chunk | output | CHUNK_CNT_W | Chunk number within the page |

## Verification
Several properties are checked in every cycle: the pulse timing against an independent count of accepted bytes, the chunk number carried with each pulse, the forced low bits of byte 0, constant readiness, and the absence of a pulse after idle or start-of-page cycles. The parity content of the code can only be shown by the bench's scenarios. These are chunks with one or two chosen bytes at chosen positions, so that every column group and both halves of the position index move particular bits. The same holds for clearing between back-to-back chunks, a restart in the middle of a chunk, idle cycles carrying junk data, and the wrap of the chunk counter.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int BYTE_W      = 8;
    localparam int CHUNK_BYTES = 256;
    localparam int IDX_W       = $clog2(CHUNK_BYTES);
    localparam int HALF_W      = IDX_W / 2;

    typedef struct packed {
        logic [BYTE_W-1:0] b2;
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b0;
    } ecc_code_t;

    // Column parity contribution of one data byte (bits 1:0 unused).
    function automatic logic [BYTE_W-1:0] col_terms(input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] r;
        r    = '0;
        r[2] = d[0] ^ d[2] ^ d[4] ^ d[6];
        r[3] = d[1] ^ d[3] ^ d[5] ^ d[7];
        r[4] = d[0] ^ d[1] ^ d[4] ^ d[5];
        r[5] = d[2] ^ d[3] ^ d[6] ^ d[7];
        r[6] = ^d[3:0];
        r[7] = ^d[7:4];
        return r;
    endfunction

    // Final form: invert everything, set the two spare bits of byte 0.
    function automatic ecc_code_t seal(input ecc_code_t a);
        ecc_code_t r;
        r.b2 = ~a.b2;
        r.b1 = ~a.b1;
        r.b0 = ~a.b0 | 8'h03;
        return r;
    endfunction

endpackage

// File: rtl/ecc_chunk_tracker.sv
module ecc_chunk_tracker
    import ecc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             sop,
    output logic [IDX_W-1:0] eff_idx,
    output logic [CNT_W-1:0] eff_chunk,
    output logic             first,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNK_BYTES - 1);

    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] chunk_q;

    always_comb begin
        eff_idx   = sop ? '0 : idx_q;
        eff_chunk = sop ? '0 : chunk_q;
        first     = (eff_idx == '0);
        last      = (eff_idx == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            chunk_q <= '0;
        end else if (accept) begin
            if (last) begin
                idx_q   <= '0;
                chunk_q <= eff_chunk + {{(CNT_W-1){1'b0}}, 1'b1};
            end else begin
                idx_q   <= eff_idx + {{(IDX_W-1){1'b0}}, 1'b1};
                chunk_q <= eff_chunk;
            end
        end
    end
endmodule

// File: rtl/ecc_byte_contrib.sv
module ecc_byte_contrib
    import ecc_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    input  logic [IDX_W-1:0]  idx,
    output ecc_code_t         contrib
);
    logic              odd;
    logic [BYTE_W-1:0] lo_rows;
    logic [BYTE_W-1:0] hi_rows;

    assign odd = ^data;

    // Each index bit selects one of a pair of row-parity bits.
    for (genvar k = 0; k < HALF_W; k++) begin : g_rows
        assign lo_rows[2*k]   = odd & ~idx[k];
        assign lo_rows[2*k+1] = odd &  idx[k];
        assign hi_rows[2*k]   = odd & ~idx[k+HALF_W];
        assign hi_rows[2*k+1] = odd &  idx[k+HALF_W];
    end

    always_comb begin
        contrib.b0 = col_terms(data);
        contrib.b1 = hi_rows;
        contrib.b2 = lo_rows;
    end
endmodule

// File: rtl/ecc_accum.sv
module ecc_accum
    import ecc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             first,
    input  logic             last,
    input  ecc_code_t        contrib,
    input  logic [CNT_W-1:0] chunk,
    output logic             out_valid,
    output ecc_code_t        out_code,
    output logic [CNT_W-1:0] out_chunk
);
    ecc_code_t acc_q;
    ecc_code_t acc_next;

    always_comb begin
        acc_next = (first ? '0 : acc_q) ^ contrib;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_code  <= '0;
            out_chunk <= '0;
        end else begin
            out_valid <= accept & last;
            if (accept) begin
                acc_q <= acc_next;
                if (last) begin
                    out_code  <= seal(acc_next);
                    out_chunk <= chunk;
                end
            end
        end
    end
endmodule

// File: rtl/hamming_ecc_gen.sv
module hamming_ecc_gen
    import ecc_pkg::*;
#(
    parameter int CHUNK_CNT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_sop,
    input  logic [7:0]             in_data,
    output logic                   out_valid,
    output logic [23:0]            out_code,
    output logic [CHUNK_CNT_W-1:0] out_chunk
);
    logic                   ready_q;
    logic                   accept;
    logic [IDX_W-1:0]       eff_idx;
    logic [CHUNK_CNT_W-1:0] eff_chunk;
    logic                   first;
    logic                   last;
    ecc_code_t              contrib;
    ecc_code_t              code;

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
    end

    assign in_ready = ready_q;
    assign accept   = in_valid & ready_q;

    ecc_chunk_tracker #(.CNT_W(CHUNK_CNT_W)) i_track (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .sop       (in_sop),
        .eff_idx   (eff_idx),
        .eff_chunk (eff_chunk),
        .first     (first),
        .last      (last)
    );

    ecc_byte_contrib i_contrib (
        .data    (in_data),
        .idx     (eff_idx),
        .contrib (contrib)
    );

    ecc_accum #(.CNT_W(CHUNK_CNT_W)) i_accum (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .first     (first),
        .last      (last),
        .contrib   (contrib),
        .chunk     (eff_chunk),
        .out_valid (out_valid),
        .out_code  (code),
        .out_chunk (out_chunk)
    );

    assign out_code = code;
endmodule

// File: rtl/hamming_ecc_gen_checker.sv
module hamming_ecc_gen_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_sop,
    input logic             out_valid,
    input logic [23:0]      out_code,
    input logic [CNT_W-1:0] out_chunk
);
    logic             acc;
    logic [7:0]       ck_idx;
    logic [CNT_W-1:0] ck_chunk;
    logic [7:0]       e_idx;
    logic [CNT_W-1:0] e_chunk;
    logic             ck_fire;
    logic [CNT_W-1:0] ck_done;

    assign acc = in_valid & in_ready;

    always_comb begin
        e_idx   = in_sop ? 8'd0 : ck_idx;
        e_chunk = in_sop ? '0 : ck_chunk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_idx   <= 8'd0;
            ck_chunk <= '0;
            ck_fire  <= 1'b0;
            ck_done  <= '0;
        end else begin
            ck_fire <= acc && (e_idx == 8'd255);
            if (acc) begin
                ck_idx <= e_idx + 8'd1;
                if (e_idx == 8'd255) begin
                    ck_chunk <= e_chunk + {{(CNT_W-1){1'b0}}, 1'b1};
                    ck_done  <= e_chunk;
                end else begin
                    ck_chunk <= e_chunk;
                end
            end
        end
    end

    p_ready_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> in_ready);

    p_spare_bits_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_code[1:0] == 2'b11));

    p_pulse_timing_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid == ck_fire);

    p_chunk_number_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_chunk == ck_done));

    p_sop_no_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (acc && in_sop) |=> !out_valid);

    p_idle_no_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !out_valid);
endmodule

bind hamming_ecc_gen hamming_ecc_gen_checker #(.CNT_W(CHUNK_CNT_W)) i_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sop    (in_sop),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_chunk (out_chunk)
);

// File: tb/test_hamming_ecc_gen.sv
module test_hamming_ecc_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 4;
    localparam int NVEC       = 6;

    typedef struct packed {
        logic [7:0]  pa;
        logic [7:0]  va;
        logic [7:0]  pb;
        logic [7:0]  vb;
        logic [23:0] exp;
    } vec_t;

    // One chunk per entry: byte pa holds va, byte pb holds vb (xor), rest zero.
    localparam vec_t VEC [NVEC] = '{
        '{8'h00, 8'h01, 8'h00, 8'h00, 24'hAAAAAB},
        '{8'h00, 8'h00, 8'h00, 8'h00, 24'hFFFFFF},
        '{8'hFF, 8'h80, 8'h00, 8'h00, 24'h555557},
        '{8'h0F, 8'h03, 8'h00, 8'h00, 24'hFFFFF3},
        '{8'hA5, 8'h10, 8'h00, 8'h00, 24'h99666B},
        '{8'h00, 8'h01, 8'h01, 8'h01, 24'hFCFFFF}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_sop = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          out_valid;
    logic [23:0]   out_code;
    logic [CW-1:0] out_chunk;

    int checks = 0;
    int errors = 0;
    int bidx = 0;
    logic exp_fire = 1'b0;
    logic done = 1'b0;
    int cap_n = 0;
    logic [23:0]   cap_code  [32];
    logic [CW-1:0] cap_chunk [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    hamming_ecc_gen #(.CHUNK_CNT_W(CW)) i_hamming_ecc_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_data(in_data), .out_valid(out_valid),
        .out_code(out_code), .out_chunk(out_chunk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Pulse timing (R6) and capture of every code, sampled at negedge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid || exp_fire)
                check(out_valid == exp_fire, "R6 pulse", int'(out_valid), int'(exp_fire));
            if (out_valid && cap_n < 32) begin
                cap_code[cap_n]  = out_code;
                cap_chunk[cap_n] = out_chunk;
                cap_n++;
            end
        end
    end

    task automatic put(input logic [7:0] d, input logic sop);
        bit lst;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = sop;
        @(posedge clk);
        if (sop) bidx = 0;
        lst = (bidx == 255);
        bidx = lst ? 0 : bidx + 1;
        exp_fire = lst;
    endtask

    task automatic idle(input logic [7:0] junk);
        @(negedge clk);
        in_valid = 1'b0; in_data = junk; in_sop = 1'b0;
        @(posedge clk);
        exp_fire = 1'b0;
    endtask

    task automatic send_vec(input vec_t v, input logic sop_first, input int gap_every);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            d = ((i == int'(v.pa)) ? v.va : 8'h00) ^ ((i == int'(v.pb)) ? v.vb : 8'h00);
            put(d, sop_first && (i == 0));
            if (gap_every > 0 && (i % gap_every) == 0) idle(8'hFF);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);

        // Table walk: one page, chunks back to back (R2 R3 R4 R5 R7 R8)
        cap_n = 0;
        for (int v = 0; v < NVEC; v++) send_vec(VEC[v], v == 0, 0);
        idle(8'h00);
        check(cap_n == NVEC, "R6 count", cap_n, NVEC);
        for (int v = 0; v < NVEC; v++) begin
            check(cap_code[v] == VEC[v].exp, "R2 R3 R4 R5 R8 code",
                  int'(cap_code[v]), int'(VEC[v].exp));
            check(cap_chunk[v] == CW'(v), "R7 chunk", int'(cap_chunk[v]), v);
        end

        // R9: restart mid-chunk, partial chunk dropped
        cap_n = 0;
        for (int i = 0; i < 100; i++) put(8'h01, i == 0);
        check(cap_n == 0, "R9 no code for partial", cap_n, 0);
        send_vec(VEC[0], 1'b1, 0);
        idle(8'h00);
        check(cap_n == 1, "R9 count", cap_n, 1);
        check(cap_code[0] == 24'hAAAAAB, "R9 code", int'(cap_code[0]), 24'hAAAAAB);
        check(cap_chunk[0] == '0, "R9 chunk", int'(cap_chunk[0]), 0);

        // R10: idle cycles carrying junk data
        cap_n = 0;
        send_vec(VEC[4], 1'b1, 7);
        idle(8'hFF);
        check(cap_n == 1, "R10 count", cap_n, 1);
        check(cap_code[0] == 24'h99666B, "R10 code", int'(cap_code[0]), 24'h99666B);

        // R7: chunk counter wraps after 2^CW chunks
        cap_n = 0;
        for (int c = 0; c < 17; c++) send_vec(VEC[1], c == 0, 0);
        idle(8'h00);
        check(cap_n == 17, "R7 wrap count", cap_n, 17);
        check(cap_chunk[15] == 4'hF, "R7 chunk 15", int'(cap_chunk[15]), 15);
        check(cap_chunk[16] == 4'h0, "R7 wrap", int'(cap_chunk[16]), 0);
        check(cap_code[16] == 24'hFFFFFF, "R8 zero chunk", int'(cap_code[16]), 24'hFFFFFF);

        finish_run();
    end
endmodule